// File: doc/BRIEF.md
# Single Precision Floating Point Multiplier

This block takes two 32-bit single precision words and produces their 32-bit single precision product one clock after they are presented. The sign, the exponent and the significand are handled on separate paths and merged at the end. The sign is the exclusive OR of the operand signs. The exponent is the sum of the two biased exponents less the bias of 127, held in a 10-bit signed intermediate so that out-of-range values remain visible.

The significand path restores the hidden leading one, which gives two 24-bit significands. The 48-bit product is not formed by one wide multiplier. It is assembled from nine 8x8 limb products, summed along their weight diagonals. The product is then normalized with at most one right shift and rounded to nearest with ties to even. A carry out of the rounding step causes one more shift.

The two range flags are deliberately simple. A result exponent that is too large gives a signed infinity and raises the overflow flag. One that is too small gives a signed zero and raises the underflow flag. Subnormal inputs, NaN payloads, traps and other rounding modes are not supported.

Top module: `fp32_mul`

## Requirements
- R1: The result sign (bit 31) equals the XOR of bit 31 of the two operands, for every accepted pair, including zero, overflow and underflow results.
- R2: For two normal operands (exponent field in bits 30:23, fraction field in bits 22:0), the result exponent is exp_a + exp_b - 127. The result fraction comes from the product of the two significands, each formed as a leading 1 followed by the 23 fraction bits. Example: 2.0 x 3.0 gives 0x40C00000.
- R3: When the final exponent (after normalization and rounding) is 255 or more, the overflow flag is 1 and the result is a signed infinity (exponent 0xFF, fraction 0).
- R4: When the final exponent is 0 or less, the underflow flag is 1 and the result is a signed zero.
- R5: An operand whose exponent field is 0 is treated as zero. The result is then a signed zero, and both flags are 0.
- R6: When the significand product is 2.0 or more, it is shifted right by one place and the exponent is raised by one.
- R7: The product is rounded to 24 significant bits with round to nearest, ties to even. The guard bit and the sticky bit are taken from the discarded low product bits.
- R8: If rounding carries out of the 24-bit significand, the result is renormalized with one more right shift and one more exponent increment. Example: 0x3FFFF830 x 0x3F8003E8 gives 0x40000000.
- R9: valid_out is valid_in delayed by exactly one clock. The result and the flags for an accepted pair appear in that same cycle.
- R10: In a cycle with valid_in at 0, the operands are ignored, and the result and flags keep their previous values.
- R11: While rst is 1, valid_out, result, overflow and underflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands on op_a/op_b are accepted this cycle |
| op_a | input | 32 | First single precision operand |
| op_b | input | 32 | Second single precision operand |
| valid_out | output | 1 | result and flags hold a new product |
| result | output | 32 | Single precision product |
| ovf | output | 1 | Exponent overflow, result forced to infinity |
| unf | output | 1 | Exponent underflow, result flushed to zero |

## Verification
The bench targets four kinds of corner case:
- Exact rounding ties. A tie with an odd kept LSB must round up, and one with an even LSB must stay. A design that rounds half-up, or simply truncates, gets one of the two wrong by one unit in the last place.
- A product that rounds up to exactly 2.0. A design without the second renormalization would return a fraction of zero with the exponent one too small.
- The exponent boundaries on either side of 255 and of 0. An off-by-one compare there would raise a flag one step early or one step late.
- A zero operand paired with a large operand. This exposes any design that lets the zero test lose to the overflow test.

Idle cycles with random operands show whether the output register wrongly follows its inputs.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam int EXPI_W  = EXP_W + 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
    } fp_unpacked_t;

    typedef struct packed {
        logic ovf;
        logic unf;
    } fp_flags_t;

    // zero exponent field is taken as zero; hidden one is restored otherwise
    function automatic fp_unpacked_t fp_unpack(input fp_word_t w);
        fp_unpacked_t u;
        u.sign = w.sign;
        u.zero = (w.exp == '0);
        u.exp  = w.exp;
        u.sig  = {1'b1, w.frac};
        return u;
    endfunction

    function automatic logic signed [EXPI_W-1:0] fp_exp_sum(
        input logic [EXP_W-1:0] ea,
        input logic [EXP_W-1:0] eb
    );
        logic signed [EXPI_W-1:0] s;
        s = $signed({2'b00, ea}) + $signed({2'b00, eb}) - $signed(EXPI_W'(BIAS));
        return s;
    endfunction

endpackage

// File: rtl/fpm_limb_mult.sv
module fpm_limb_mult #(
    parameter int SIG_W  = 24,
    parameter int LIMB_W = 8
) (
    input  logic [SIG_W-1:0]   a,
    input  logic [SIG_W-1:0]   b,
    output logic [2*SIG_W-1:0] prod
);
    localparam int LIMBS = (SIG_W + LIMB_W - 1) / LIMB_W;
    localparam int PAD_W = LIMBS * LIMB_W;
    localparam int ACC_W = 2 * PAD_W;

    logic [PAD_W-1:0]    a_pad;
    logic [PAD_W-1:0]    b_pad;
    logic [2*LIMB_W-1:0] pp [LIMBS][LIMBS];
    logic [ACC_W-1:0]    acc;

    assign a_pad = PAD_W'(a);
    assign b_pad = PAD_W'(b);

    for (genvar i = 0; i < LIMBS; i++) begin : g_row
        for (genvar j = 0; j < LIMBS; j++) begin : g_col
            assign pp[i][j] = a_pad[i*LIMB_W +: LIMB_W] * b_pad[j*LIMB_W +: LIMB_W];
        end
    end

    // sum diagonal by diagonal: limb pair (i,j) carries weight 2^((i+j)*LIMB_W)
    always_comb begin
        acc = '0;
        for (int d = 0; d <= 2 * (LIMBS - 1); d++) begin
            for (int i = 0; i < LIMBS; i++) begin
                if (d - i >= 0 && d - i < LIMBS) begin
                    acc = acc + (ACC_W'(pp[i][d-i]) << (d * LIMB_W));
                end
            end
        end
    end

    assign prod = acc[2*SIG_W-1:0];

endmodule

// File: rtl/fpm_round_rne.sv
module fpm_round_rne #(
    parameter int SIG_W  = 24,
    parameter int EXPI_W = 10
) (
    input  logic [2*SIG_W-1:0]       prod,
    input  logic signed [EXPI_W-1:0] exp_in,
    output logic [SIG_W-2:0]         frac_out,
    output logic signed [EXPI_W-1:0] exp_out
);
    localparam int P = 2 * SIG_W;

    logic             top;
    logic [SIG_W-1:0] kept_hi, kept_lo, kept;
    logic             guard_hi, guard_lo, guard;
    logic             sticky_hi, sticky_lo, sticky;
    logic             up;
    logic [SIG_W:0]   summed;
    logic             carry;

    assign top       = prod[P-1];
    assign kept_hi   = prod[P-1 -: SIG_W];
    assign guard_hi  = prod[P-SIG_W-1];
    assign sticky_hi = |prod[P-SIG_W-2:0];
    assign kept_lo   = prod[P-2 -: SIG_W];
    assign guard_lo  = prod[P-SIG_W-2];
    assign sticky_lo = |prod[P-SIG_W-3:0];

    always_comb begin
        kept   = top ? kept_hi   : kept_lo;
        guard  = top ? guard_hi  : guard_lo;
        sticky = top ? sticky_hi : sticky_lo;
        up     = guard & (sticky | kept[0]);
        summed = {1'b0, kept} + (SIG_W+1)'(up);
        carry  = summed[SIG_W];
        frac_out = carry ? summed[SIG_W-1:1] : summed[SIG_W-2:0];
        exp_out  = exp_in + $signed(EXPI_W'(top)) + $signed(EXPI_W'(carry));
    end

endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
    import fpm_pkg::*;
(
    input  logic                     sign,
    input  logic                     zero,
    input  logic signed [EXPI_W-1:0] exp_in,
    input  logic [FRAC_W-1:0]        frac_in,
    output fp_word_t                 word,
    output fp_flags_t                flags
);
    always_comb begin
        flags     = '0;
        word.sign = sign;
        word.exp  = exp_in[EXP_W-1:0];
        word.frac = frac_in;
        if (zero) begin
            word.exp  = '0;
            word.frac = '0;
        end else if (exp_in >= $signed(EXPI_W'(EXP_TOP))) begin
            flags.ovf = 1'b1;
            word.exp  = '1;
            word.frac = '0;
        end else if (exp_in <= $signed(EXPI_W'(0))) begin
            flags.unf = 1'b1;
            word.exp  = '0;
            word.frac = '0;
        end
    end

endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
    import fpm_pkg::*;
#(
    parameter int LIMB_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              valid_out,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              unf
);
    fp_unpacked_t             ua, ub;
    logic                     sign_c;
    logic                     zero_c;
    logic signed [EXPI_W-1:0] exp_c;
    logic [2*SIG_W-1:0]       prod_c;
    logic [FRAC_W-1:0]        frac_r;
    logic signed [EXPI_W-1:0] exp_r;
    fp_word_t                 word_c;
    fp_flags_t                flags_c;

    assign ua     = fp_unpack(fp_word_t'(op_a));
    assign ub     = fp_unpack(fp_word_t'(op_b));
    assign sign_c = ua.sign ^ ub.sign;
    assign zero_c = ua.zero | ub.zero;
    assign exp_c  = fp_exp_sum(ua.exp, ub.exp);

    fpm_limb_mult #(.SIG_W(SIG_W), .LIMB_W(LIMB_W)) i_mult (
        .a    (ua.sig),
        .b    (ub.sig),
        .prod (prod_c)
    );

    fpm_round_rne #(.SIG_W(SIG_W), .EXPI_W(EXPI_W)) i_round (
        .prod     (prod_c),
        .exp_in   (exp_c),
        .frac_out (frac_r),
        .exp_out  (exp_r)
    );

    fpm_pack i_pack (
        .sign    (sign_c),
        .zero    (zero_c),
        .exp_in  (exp_r),
        .frac_in (frac_r),
        .word    (word_c),
        .flags   (flags_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                result <= word_c;
                ovf    <= flags_c.ovf;
                unf    <= flags_c.unf;
            end
        end
    end

endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_in,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        valid_out,
    input logic [31:0] result,
    input logic        ovf,
    input logic        unf
);
    assert_sign_xor_R1: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> result[31] == $past(op_a[31] ^ op_b[31]));

    assert_ovf_is_inf_R3: assert property (@(posedge clk) disable iff (rst)
        ovf |-> result[30:0] == 31'h7F800000);

    assert_unf_is_zero_R4: assert property (@(posedge clk) disable iff (rst)
        unf |-> result[30:0] == 31'h0);

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));

    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (op_a[30:23] == 8'h0 || op_b[30:23] == 8'h0))
            |=> (result[30:0] == 31'h0 && !ovf && !unf));

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    assert_valid_fall_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result) && $stable(ovf) && $stable(unf)));

endmodule

bind fp32_mul fp32_mul_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .op_a      (op_a),
    .op_b      (op_b),
    .valid_out (valid_out),
    .result    (result),
    .ovf       (ovf),
    .unf       (unf)
);

// File: tb/test_fp32_mul.sv
`timescale 1ns/1ps
module test_fp32_mul;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        valid_out;
    logic [31:0] result;
    logic        ovf;
    logic        unf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [33:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [33:0] last_out = '0;

    always #2 clk = ~clk;

    fp32_mul i_fp32_mul (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .op_a      (op_a),
        .op_b      (op_b),
        .valid_out (valid_out),
        .result    (result),
        .ovf       (ovf),
        .unf       (unf)
    );

    // reference: returns {ovf, unf, word}
    function automatic logic [33:0] ref_mul(logic [31:0] a, logic [31:0] b);
        logic   s;
        longint ma, mb, p, q, rem, half;
        int     e, sh;
        s = a[31] ^ b[31];
        if (a[30:23] == 8'h0 || b[30:23] == 8'h0) return {2'b00, s, 31'h0};
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        p  = ma * mb;
        e  = int'(a[30:23]) + int'(b[30:23]) - 127;
        sh = (p >= (longint'(1) << 47)) ? 24 : 23;
        if (sh == 24) e = e + 1;
        q    = p >> sh;
        rem  = p - (q << sh);
        half = longint'(1) << (sh - 1);
        if (rem > half || (rem == half && q[0])) q = q + 1;
        if (q == (longint'(1) << 24)) begin
            q = q >> 1;
            e = e + 1;
        end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'h0};
        if (e <= 0)   return {2'b01, s, 31'h0};
        return {2'b00, s, e[7:0], q[22:0]};
    endfunction

    task automatic check(string tag, logic [33:0] act, logic [33:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual ovf=%0b unf=%0b res=%08h expected ovf=%0b unf=%0b res=%08h",
                     tag, act[33], act[32], act[31:0], expv[33], expv[32], expv[31:0]);
        end
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, string tag, logic [33:0] expv);
        item_t it;
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        valid_in = 1'b1;
        it.a = a; it.b = b; it.exp = expv; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_in = 1'b0;
            op_a     = $urandom;
            op_b     = $urandom;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (valid_out) begin
                if (sb.size() == 0) begin
                    check("R9 unexpected valid_out", {1'b1, 33'h0}, 34'h0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.tag, {ovf, unf, result}, it.exp);
                end
                last_out = {ovf, unf, result};
            end else begin
                check("R10 hold while idle", {ovf, unf, result}, last_out);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R9 watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset state", {valid_out, ovf, unf, result[30:0]}, 34'h0);
        @(negedge clk);
        rst = 1'b0;

        // R2 plain products
        drive(32'h3F800000, 32'h3F800000, "R2 1.0x1.0", {2'b00, 32'h3F800000});
        drive(32'h40000000, 32'h40400000, "R2 2.0x3.0", {2'b00, 32'h40C00000});
        // R1 sign
        drive(32'hBFC00000, 32'h40000000, "R1 -1.5x2.0", {2'b00, 32'hC0400000});
        drive(32'hC0000000, 32'hC0400000, "R1 -2x-3", {2'b00, 32'h40C00000});
        idle(2);
        // R6 product >= 2.0 needs shift: 1.5 x 1.5 = 2.25
        drive(32'h3FC00000, 32'h3FC00000, "R6 1.5x1.5", {2'b00, 32'h40100000});
        // R7 tie with odd kept lsb rounds up, even lsb stays
        drive(32'h3F800001, 32'h3FC00000, "R7 tie odd", {2'b00, 32'h3FC00002});
        drive(32'h3F800003, 32'h3FC00000, "R7 tie even", {2'b00, 32'h3FC00004});
        drive(32'h3F800001, 32'h3F800001, "R7 below half", {2'b00, 32'h3F800002});
        // R8 rounding carry-out
        drive(32'h3FFFF830, 32'h3F8003E8, "R8 round carry", {2'b00, 32'h40000000});
        idle(3);
        // R3 overflow boundary
        drive(32'h7F000000, 32'h3F800000, "R3 exp 254 no ovf", {2'b00, 32'h7F000000});
        drive(32'h7F000000, 32'h40000000, "R3 exp 255 ovf", {2'b10, 32'h7F800000});
        drive(32'hFF000000, 32'h7F000000, "R3 neg ovf", {2'b10, 32'hFF800000});
        // R4 underflow boundary
        drive(32'h00800000, 32'h3F800000, "R4 exp 1 no unf", {2'b00, 32'h00800000});
        drive(32'h00800000, 32'h3F000000, "R4 exp 0 unf", {2'b01, 32'h00000000});
        drive(32'h80800000, 32'h3F000000, "R4 neg unf", {2'b01, 32'h80000000});
        // R5 zero operand
        drive(32'h80000000, 32'h40400000, "R5 -0x3", {2'b00, 32'h80000000});
        drive(32'h7F000000, 32'h00000000, "R5 big x 0", {2'b00, 32'h00000000});
        drive(32'h00000000, 32'h80000000, "R5 0x-0", {2'b00, 32'h80000000});
        idle(4);
        // random sweep against reference (R2, R6, R7 mixed patterns)
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (k % 2 == 0) begin
                ra[30:23] = 8'(64 + ($urandom % 128));
                rb[30:23] = 8'(64 + ($urandom % 128));
            end
            drive(ra, rb, "R2 R7 random", ref_mul(ra, rb));
            if (k % 7 == 0) idle(1);
        end
        idle(4);
        if (sb.size() != 0)
            check("R9 pending results", 34'(sb.size()), 34'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule